// File: doc/BRIEF.md
# Static Memory Strobe Sequencer with Slow-Clock Override

This block drives the control side of an external static memory bus. A requester presents one access at a time (address, write data, read/write flag and a chip-select index) on a request/acknowledge port. The block then produces the active-low chip-select, read-strobe and write-strobe waveforms and holds the address. Each strobe has a setup delay, a pulse length and a total cycle length, all counted in clock cycles. These values come from a per-chip-select bank of timing registers that is loaded through a small register-write port.

A slow-clock input is raised when the system clock has been lowered to a very slow rate. While it is high, the block ignores the programmed timings and uses one fixed minimal timing set on every chip select. The programmed registers keep their contents, so they apply again as soon as the input falls. The input is sampled only when an access is accepted, so an access always runs to completion with the timing set it started with.

Top module: `sram_strobe_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, `mem_ncs` is all ones, `mem_nrd` and `mem_nwe` are 1, and `req_ack` is 0. When idle, `mem_addr` keeps the address of the last access, and it is 0 after reset.
- R2: An access is accepted on a clock edge at which `req` is 1, no access is running and `req_ack` is 0. The access then takes L consecutive cycles, starting with the cycle after that edge. `req_ack` is 1 for exactly the one cycle that follows the last of these cycles.
- R3: Number the access cycles from k = 0. A strobe with setup S and pulse P is low exactly for S <= k < S+P. This applies to `mem_nrd` on reads, to `mem_nwe` on writes, and to the selected bit of `mem_ncs` using the chip-select setup and pulse. A setup of 0 makes the strobe low in cycle 0. A pulse of 0 keeps the strobe high for the whole access. The strobe of the other direction stays high, so read and write strobes are never low together.
- R4: The access length is L = max(cycle, strobe setup + strobe pulse, chip-select setup + chip-select pulse, 1).
- R5: A write on the register port, with `cfg_we` at 1, sets one field of the bank selected by `cfg_cs`. The value is taken from the low bits of `cfg_wdata`: 6 bits for a setup, 7 bits for a pulse, 9 bits for a cycle. The field codes are 0 read-strobe setup, 1 read-strobe pulse, 2 chip-select read setup, 3 chip-select read pulse, 4 read cycle, 5 write-strobe setup, 6 write-strobe pulse, 7 chip-select write setup, 8 chip-select write pulse and 9 write cycle. Codes 10 to 15 change nothing.
- R6: After reset, every bank holds strobe setup 1, strobe pulse 2, chip-select setup 0, chip-select pulse 4 and cycle 4, for both reads and writes.
- R7: A read accepted while `slow_clk_mode` is 1 uses read-strobe setup 1, read-strobe pulse 1, chip-select setup 0, chip-select pulse 2 and cycle 2, whatever has been programmed.
- R8: A write accepted while `slow_clk_mode` is 1 uses write-strobe setup 1, write-strobe pulse 1, chip-select setup 0, chip-select pulse 3 and cycle 3. The fixed sets of R7 and R8 apply on every chip select.
- R9: `slow_clk_mode` is sampled only on the edge that accepts an access. A change during an access does not alter that access. Once the input is low again, the programmed values apply unchanged.
- R10: For a read, `req_rdata` takes `mem_rdata` on the edge that ends cycle C-1. C is the smaller of the read-strobe end and the chip-select end, counting only strobes whose pulse is not 0, or L if neither pulse is non-zero. `req_rdata` then holds that value until the next read.
- R11: During an access, only the `mem_ncs` bit matching `req_cs` may go low. `mem_addr` carries the accepted address, and `mem_wdata` carries the accepted write data, for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk_mode | input | 1 | High selects the fixed slow-clock timing set |
| req | input | 1 | Access request, held until acknowledged |
| req_we | input | 1 | 1 for a write, 0 for a read |
| req_cs | input | 2 | Chip-select index of the access |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Captured read data |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_cs | input | 2 | Bank selected by a register write |
| cfg_field | input | 4 | Field code of a register write |
| cfg_wdata | input | 9 | Register write value |
| mem_addr | output | 24 | Memory address |
| mem_ncs | output | 4 | Active-low chip selects |
| mem_nrd | output | 1 | Active-low read strobe |
| mem_nwe | output | 1 | Active-low write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |

## Verification
The embedded assertions check several rules on every cycle: all strobes are high when idle, the acknowledge lasts one cycle, at most one chip select is low, the read and write strobes are never low together, and the address and latched timing stay frozen during an access. These per-cycle checks cannot show that the strobes have the right shape. The bench's scenarios cover that: the exact window in which each strobe is low, the extension of a short cycle, the fixed slow-clock sets on several chip selects, and the restoration of programmed values. They also show which memory data word is captured, and that a change of the slow-clock input in the middle of an access has no effect.

// File: rtl/sst_pkg.sv
package sst_pkg;

    localparam int SETUP_W = 6;
    localparam int PULSE_W = 7;
    localparam int CYCLE_W = 9;

    typedef struct packed {
        logic [SETUP_W-1:0] str_setup;
        logic [PULSE_W-1:0] str_pulse;
        logic [SETUP_W-1:0] cs_setup;
        logic [PULSE_W-1:0] cs_pulse;
        logic [CYCLE_W-1:0] cycle;
    } timing_t;

    // Normalised access plan, all values counted in access cycles
    typedef struct packed {
        logic [CYCLE_W-1:0] str_on;
        logic [CYCLE_W-1:0] str_off;
        logic [CYCLE_W-1:0] cs_on;
        logic [CYCLE_W-1:0] cs_off;
        logic [CYCLE_W-1:0] last_k;
        logic [CYCLE_W-1:0] cap_k;
    } plan_t;

    typedef enum logic [3:0] {
        FLD_RD_STR_SETUP = 4'd0,
        FLD_RD_STR_PULSE = 4'd1,
        FLD_RD_CS_SETUP  = 4'd2,
        FLD_RD_CS_PULSE  = 4'd3,
        FLD_RD_CYCLE     = 4'd4,
        FLD_WR_STR_SETUP = 4'd5,
        FLD_WR_STR_PULSE = 4'd6,
        FLD_WR_CS_SETUP  = 4'd7,
        FLD_WR_CS_PULSE  = 4'd8,
        FLD_WR_CYCLE     = 4'd9
    } field_e;

    localparam timing_t SLOW_RD_TIM = '{str_setup: 6'd1, str_pulse: 7'd1,
                                        cs_setup: 6'd0, cs_pulse: 7'd2, cycle: 9'd2};
    localparam timing_t SLOW_WR_TIM = '{str_setup: 6'd1, str_pulse: 7'd1,
                                        cs_setup: 6'd0, cs_pulse: 7'd3, cycle: 9'd3};
    localparam timing_t RESET_TIM   = '{str_setup: 6'd1, str_pulse: 7'd2,
                                        cs_setup: 6'd0, cs_pulse: 7'd4, cycle: 9'd4};

endpackage

// File: rtl/sst_timing_regs.sv
module sst_timing_regs
    import sst_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CS_W-1:0]    cfg_cs,
    input  logic [3:0]         cfg_field,
    input  logic [CYCLE_W-1:0] cfg_wdata,
    output timing_t            rd_tim [NUM_CS],
    output timing_t            wr_tim [NUM_CS]
);

    typedef struct packed {
        timing_t rd;
        timing_t wr;
    } bank_t;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_bank
        bank_t bank_d, bank_q;

        always_comb begin
            bank_d = bank_q;
            if (cfg_we && cfg_cs == CS_W'(g)) begin
                case (cfg_field)
                    FLD_RD_STR_SETUP: bank_d.rd.str_setup = cfg_wdata[SETUP_W-1:0];
                    FLD_RD_STR_PULSE: bank_d.rd.str_pulse = cfg_wdata[PULSE_W-1:0];
                    FLD_RD_CS_SETUP:  bank_d.rd.cs_setup  = cfg_wdata[SETUP_W-1:0];
                    FLD_RD_CS_PULSE:  bank_d.rd.cs_pulse  = cfg_wdata[PULSE_W-1:0];
                    FLD_RD_CYCLE:     bank_d.rd.cycle     = cfg_wdata;
                    FLD_WR_STR_SETUP: bank_d.wr.str_setup = cfg_wdata[SETUP_W-1:0];
                    FLD_WR_STR_PULSE: bank_d.wr.str_pulse = cfg_wdata[PULSE_W-1:0];
                    FLD_WR_CS_SETUP:  bank_d.wr.cs_setup  = cfg_wdata[SETUP_W-1:0];
                    FLD_WR_CS_PULSE:  bank_d.wr.cs_pulse  = cfg_wdata[PULSE_W-1:0];
                    FLD_WR_CYCLE:     bank_d.wr.cycle     = cfg_wdata;
                    default:          bank_d = bank_q;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q <= '{rd: RESET_TIM, wr: RESET_TIM};
            end else begin
                bank_q <= bank_d;
            end
        end

        assign rd_tim[g] = bank_q.rd;
        assign wr_tim[g] = bank_q.wr;
    end

endmodule

// File: rtl/sst_timing_select.sv
module sst_timing_select
    import sst_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic            slow_clk_mode,
    input  logic            acc_we,
    input  logic [CS_W-1:0] acc_cs,
    input  timing_t         rd_tim [NUM_CS],
    input  timing_t         wr_tim [NUM_CS],
    output plan_t           plan
);

    timing_t            tim;
    logic [CYCLE_W-1:0] len;
    logic [CYCLE_W-1:0] cap_end;

    always_comb begin
        // Override replaces the programmed set on every chip select
        if (slow_clk_mode) begin
            tim = acc_we ? SLOW_WR_TIM : SLOW_RD_TIM;
        end else if (int'(acc_cs) < NUM_CS) begin
            tim = acc_we ? wr_tim[acc_cs] : rd_tim[acc_cs];
        end else begin
            tim = RESET_TIM;
        end

        plan.str_on  = CYCLE_W'(tim.str_setup);
        plan.str_off = CYCLE_W'(tim.str_setup) + CYCLE_W'(tim.str_pulse);
        plan.cs_on   = CYCLE_W'(tim.cs_setup);
        plan.cs_off  = CYCLE_W'(tim.cs_setup) + CYCLE_W'(tim.cs_pulse);

        // Stretch a short cycle so both strobes finish inside the access
        len = tim.cycle;
        if (len < plan.str_off) len = plan.str_off;
        if (len < plan.cs_off)  len = plan.cs_off;
        if (len == '0)          len = CYCLE_W'(1);
        plan.last_k = len - CYCLE_W'(1);

        // Read data sampled at the first rising strobe
        cap_end = len;
        if (tim.str_pulse != '0 && plan.str_off < cap_end) cap_end = plan.str_off;
        if (tim.cs_pulse != '0 && plan.cs_off < cap_end)   cap_end = plan.cs_off;
        plan.cap_k = cap_end - CYCLE_W'(1);
    end

endmodule

// File: rtl/sst_access_seq.sv
module sst_access_seq
    import sst_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  plan_t             plan_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] req_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NUM_CS-1:0] mem_ncs,
    output logic              mem_nrd,
    output logic              mem_nwe,
    output logic [DATA_W-1:0] mem_wdata
);

    typedef struct packed {
        logic               busy;
        logic               ack;
        logic               we;
        logic [CS_W-1:0]    cs;
        logic [CYCLE_W-1:0] k;
        plan_t              plan;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic [NUM_CS-1:0]  ncs;
        logic               nrd;
        logic               nwe;
    } seq_t;

    seq_t st_d, st_q;
    logic str_win_d;
    logic cs_win_d;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;

        if (!st_q.busy) begin
            if (req && !st_q.ack) begin
                st_d.busy  = 1'b1;
                st_d.k     = '0;
                st_d.we    = req_we;
                st_d.cs    = req_cs;
                st_d.addr  = req_addr;
                st_d.wdata = req_wdata;
                st_d.plan  = plan_in;
            end
        end else begin
            if (!st_q.we && st_q.k == st_q.plan.cap_k) begin
                st_d.rdata = mem_rdata;
            end
            if (st_q.k == st_q.plan.last_k) begin
                st_d.busy = 1'b0;
                st_d.ack  = 1'b1;
            end else begin
                st_d.k = st_q.k + CYCLE_W'(1);
            end
        end

        // Strobes registered from the next count: no decode glitches on the pins
        str_win_d = st_d.busy && st_d.k >= st_d.plan.str_on && st_d.k < st_d.plan.str_off;
        cs_win_d  = st_d.busy && st_d.k >= st_d.plan.cs_on  && st_d.k < st_d.plan.cs_off;
        st_d.nrd  = !(str_win_d && !st_d.we);
        st_d.nwe  = !(str_win_d && st_d.we);
        for (int g = 0; g < NUM_CS; g++) begin
            st_d.ncs[g] = !(cs_win_d && st_d.cs == CS_W'(g));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ncs <= '1;
            st_q.nrd <= 1'b1;
            st_q.nwe <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ack   = st_q.ack;
    assign req_rdata = st_q.rdata;
    assign mem_addr  = st_q.addr;
    assign mem_ncs   = st_q.ncs;
    assign mem_nrd   = st_q.nrd;
    assign mem_nwe   = st_q.nwe;
    assign mem_wdata = st_q.wdata;

    AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> (&mem_ncs && mem_nrd && mem_nwe)); // R1

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack); // R2

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_nrd && !mem_nwe)); // R3

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.k <= st_q.plan.last_k); // R4

    AST_PLAN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> $stable(st_q.plan)); // R9

    AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ncs)); // R11

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R11

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
    import sst_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk_mode,
    input  logic              req,
    input  logic              req_we,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] req_rdata,
    input  logic              cfg_we,
    input  logic [CS_W-1:0]   cfg_cs,
    input  logic [3:0]        cfg_field,
    input  logic [8:0]        cfg_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NUM_CS-1:0] mem_ncs,
    output logic              mem_nrd,
    output logic              mem_nwe,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    timing_t rd_tim [NUM_CS];
    timing_t wr_tim [NUM_CS];
    plan_t   plan;

    sst_timing_regs #(.NUM_CS(NUM_CS)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_cs    (cfg_cs),
        .cfg_field (cfg_field),
        .cfg_wdata (CYCLE_W'(cfg_wdata)),
        .rd_tim    (rd_tim),
        .wr_tim    (wr_tim)
    );

    sst_timing_select #(.NUM_CS(NUM_CS)) i_select (
        .slow_clk_mode (slow_clk_mode),
        .acc_we        (req_we),
        .acc_cs        (req_cs),
        .rd_tim        (rd_tim),
        .wr_tim        (wr_tim),
        .plan          (plan)
    );

    sst_access_seq #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .plan_in   (plan),
        .mem_rdata (mem_rdata),
        .req_ack   (req_ack),
        .req_rdata (req_rdata),
        .mem_addr  (mem_addr),
        .mem_ncs   (mem_ncs),
        .mem_nrd   (mem_nrd),
        .mem_nwe   (mem_nwe),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: tb/test_sram_strobe_seq.sv
module test_sram_strobe_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk_mode = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] req_rdata;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_cs = '0;
    logic [3:0]  cfg_field = '0;
    logic [8:0]  cfg_wdata = '0;
    logic [23:0] mem_addr;
    logic [3:0]  mem_ncs;
    logic        mem_nrd;
    logic        mem_nwe;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sram_strobe_seq i_sram_strobe_seq (
        .clk(clk), .rst_n(rst_n), .slow_clk_mode(slow_clk_mode),
        .req(req), .req_we(req_we), .req_cs(req_cs), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
        .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .mem_addr(mem_addr), .mem_ncs(mem_ncs), .mem_nrd(mem_nrd), .mem_nwe(mem_nwe),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] win(input int s, input int p);
        logic [63:0] m = '0;
        for (int i = 0; i < 64; i++) m[i] = (i >= s) && (i < s + p);
        return m;
    endfunction

    task automatic cfg(input int cs, input int field, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_cs = 2'(cs); cfg_field = 4'(field); cfg_wdata = 9'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access; s/p/cs_s/cs_p/cyc are the timing the requirements predict
    task automatic run_acc(input string rq, input bit we, input int cs,
                           input logic [23:0] addr, input logic [15:0] wd,
                           input int s, input int p, input int cs_s, input int cs_p,
                           input int cyc, input int flip_at);
        logic [63:0] str_seen = '0;
        logic [63:0] cs_seen = '0;
        int n = 0;
        bit other_bad = 0;
        bit hold_bad = 0;
        bit done = 0;
        int len, cap;
        @(negedge clk);
        req = 1'b1; req_we = we; req_cs = 2'(cs); req_addr = addr; req_wdata = wd;
        while (!done) begin
            @(posedge clk);
            @(negedge clk);
            if (req_ack) begin
                done = 1;
                req = 1'b0;
            end else begin
                if (n < 64) begin
                    str_seen[n] = we ? !mem_nwe : !mem_nrd;
                    cs_seen[n]  = !mem_ncs[cs];
                end
                if (we ? !mem_nrd : !mem_nwe) other_bad = 1;
                for (int g = 0; g < 4; g++) if (g != cs && !mem_ncs[g]) other_bad = 1;
                if (mem_addr !== addr || (we && mem_wdata !== wd)) hold_bad = 1;
                mem_rdata = 16'hA000 + 16'(n);
                if (n == flip_at) slow_clk_mode = !slow_clk_mode;
                n++;
                if (n > 600) done = 1;
            end
        end
        len = cyc;
        if (len < s + p) len = s + p;
        if (len < cs_s + cs_p) len = cs_s + cs_p;
        if (len < 1) len = 1;
        chk(n == len, "R2", {rq, " access length"}, n, len);
        chk(str_seen == win(s, p), rq, "data strobe low window", str_seen, win(s, p));
        chk(cs_seen == win(cs_s, cs_p), rq, "chip select low window", cs_seen, win(cs_s, cs_p));
        chk(!other_bad, "R11", "other strobe or other chip select low", other_bad, 0);
        chk(!hold_bad, "R11", "address or write data not held", hold_bad, 0);
        if (!we) begin
            cap = len;
            if (p != 0 && s + p < cap) cap = s + p;
            if (cs_p != 0 && cs_s + cs_p < cap) cap = cs_s + cs_p;
            chk(req_rdata == 16'hA000 + 16'(cap - 1), "R10", "captured read data",
                req_rdata, 16'hA000 + 16'(cap - 1));
        end
        @(negedge clk);
        chk(!req_ack, "R2", "ack lasts one cycle", req_ack, 0);
    endtask

    task automatic t_reset();
        chk(mem_ncs == 4'hF && mem_nrd && mem_nwe && !req_ack, "R1", "strobes in reset",
            {mem_ncs, mem_nrd, mem_nwe, req_ack}, 7'b1111110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_ncs == 4'hF && mem_nrd && mem_nwe && !req_ack, "R1", "strobes after reset",
            {mem_ncs, mem_nrd, mem_nwe, req_ack}, 7'b1111110);
        chk(mem_addr == 24'h0, "R1", "address after reset", mem_addr, 0);
    endtask

    task automatic t_defaults();
        run_acc("R6", 1'b0, 0, 24'h000100, 16'h0, 1, 2, 0, 4, 4, -1);
        run_acc("R6", 1'b1, 3, 24'h000200, 16'h5A5A, 1, 2, 0, 4, 4, -1);
    endtask

    task automatic t_programmed();
        cfg(1, 0, 2); cfg(1, 1, 3); cfg(1, 2, 1); cfg(1, 3, 5); cfg(1, 4, 8);
        run_acc("R5", 1'b0, 1, 24'h123456, 16'h0, 2, 3, 1, 5, 8, -1);
        cfg(2, 5, 0); cfg(2, 6, 4); cfg(2, 7, 0); cfg(2, 8, 6); cfg(2, 9, 10);
        run_acc("R3", 1'b1, 2, 24'hABCDEF, 16'hC3C3, 0, 4, 0, 6, 10, -1);
    endtask

    task automatic t_extend();
        cfg(3, 0, 3); cfg(3, 1, 4); cfg(3, 2, 0); cfg(3, 3, 2); cfg(3, 4, 2);
        run_acc("R4", 1'b0, 3, 24'h00F00F, 16'h0, 3, 4, 0, 2, 2, -1);
    endtask

    task automatic t_pulse_zero();
        cfg(0, 12, 0);  // unused code: R5, must leave bank 0 alone
        cfg(0, 1, 0);
        run_acc("R3", 1'b0, 0, 24'h000300, 16'h0, 1, 0, 0, 4, 4, -1);
    endtask

    task automatic t_slow();
        slow_clk_mode = 1'b1;
        run_acc("R7", 1'b0, 1, 24'h000400, 16'h0, 1, 1, 0, 2, 2, -1);
        run_acc("R7", 1'b0, 3, 24'h000410, 16'h0, 1, 1, 0, 2, 2, -1);
        run_acc("R8", 1'b1, 2, 24'h000500, 16'h1111, 1, 1, 0, 3, 3, -1);
        run_acc("R8", 1'b1, 0, 24'h000510, 16'h2222, 1, 1, 0, 3, 3, -1);
        slow_clk_mode = 1'b0;
        run_acc("R9", 1'b0, 1, 24'h000600, 16'h0, 2, 3, 1, 5, 8, -1);
    endtask

    task automatic t_mid_change();
        run_acc("R9", 1'b0, 1, 24'h000700, 16'h0, 2, 3, 1, 5, 8, 2);
        run_acc("R9", 1'b1, 2, 24'h000800, 16'h3333, 1, 1, 0, 3, 3, 1);
        slow_clk_mode = 1'b0;
    endtask

    task automatic t_idle_hold();
        repeat (3) @(negedge clk);
        chk(mem_addr == 24'h000800, "R1", "idle address hold", mem_addr, 24'h000800);
        chk(mem_ncs == 4'hF && mem_nrd && mem_nwe, "R1", "idle strobes high",
            {mem_ncs, mem_nrd, mem_nwe}, 6'b111111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_defaults();
        t_programmed();
        t_extend();
        t_pulse_zero();
        t_slow();
        t_mid_change();
        t_idle_hold();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule